// File: doc/BRIEF.md
# Early-Transmit Start Controller

This block sits between a word-wide transmit buffer and the byte-serial data path of an Ethernet-style transmitter. Software pushes a frame into the buffer one 32-bit word at a time. The block decides when the frame may start going out. It then streams exactly the number of payload bytes announced in the frame header, one byte per clock.

A frame starts in one of two ways. The first is an explicit software "go" strobe. The second is early start, where the buffered byte count reaches a programmable threshold. The threshold moves in coarse 32-byte steps. The all-ones setting turns early start off. The two triggers have the same effect.

While a frame is streaming, the block checks every byte it needs against the words actually written. If the output side overtakes the write side, the frame is aborted and an error pulse is raised. After every frame, whether it completes or aborts, the buffer is emptied and the trigger logic re-arms for the next frame.

Top module: `etx_start_ctrl`

## Requirements
- R1: The 6-bit threshold setting resets to 0x3F. A write takes data bits 5:0, and a read returns the setting in bits 5:0 with bits 31:6 as zero.
- R2: With the threshold at 0x3F, no amount of buffered data starts a frame. Only `tx_go` does.
- R3: With threshold T below 0x3F, suppose the write at clock edge E brings the buffered byte count (4 per word) to at least 4*(8*T+1). Then `tx_busy` rises at edge E+1, and never earlier.
- R4: A `tx_go` pulse while idle starts the frame even when the byte count is below the threshold. The frame that follows is the same as one started by the threshold.
- R5: Bits 15:0 of the first word hold the payload length, with bits 7:0 as the low byte. Stream byte k sits in word k/4 at bits 8*(k%4)+7 down to 8*(k%4). The payload is stream bytes 2 through length+1, sent in order, and `tx_last` marks the final one.
- R6: A frame whose length is 0 sends no byte and raises no error. `tx_busy` stays low.
- R7: If a byte is due but its word has not been written, the frame ends with a one-cycle `tx_err` pulse and no `tx_last`. A start with an empty buffer gives only the `tx_err` pulse.
- R8: At the end of every frame, completed or aborted, the buffer is emptied. Words written while the buffer holds 512 words are dropped.
- R9: A `tx_go` pulse or a reached threshold while a frame is busy is ignored. Triggering re-arms once the frame has ended.
- R10: While a frame is busy and data is present, one payload byte is output on every clock, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr_en | input | 1 | Write strobe for the threshold setting |
| thr_wr_data | input | 32 | Write data for the threshold setting (bits 5:0 used) |
| thr_rd_data | output | 32 | Threshold readback, upper bits zero |
| fifo_wr_en | input | 1 | Push one word into the transmit buffer |
| fifo_wr_data | input | 32 | Word pushed into the transmit buffer |
| tx_go | input | 1 | Software start strobe |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Marks the final payload byte |
| tx_err | output | 1 | One-cycle underrun / empty-start abort pulse |
| tx_busy | output | 1 | A frame is being sent |

## Verification
The bench sweeps several threshold values and checks `tx_busy` after every word up to the crossing point. A design that is off by one threshold step, or that uses `>` in place of `>=`, starts one word early or late and is caught. An underrun is forced by writing only the header word. A design that keeps streaming stale buffer contents, or that raises `tx_last` on an aborted frame, is exposed there. The buffer is filled to capacity plus one word whose value would destroy the header, so a design that wraps its write pointer sends the wrong length. Retriggers during a busy frame and a zero-length header are also exercised, so a design that lets a second start through or streams an empty frame shows extra bytes or busy cycles.

// File: rtl/etx_pkg.sv
package etx_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } etx_state_e;

  localparam logic [5:0] THR_DISABLED = 6'h3F;
  localparam int         HDR_BYTES    = 2;

endpackage

// File: rtl/etx_rst_sync.sv
module etx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/etx_thr_reg.sv
module etx_thr_reg
  import etx_pkg::*;
#(
  parameter int CW   = 10,
  parameter int CMPW = ((CW + 2) > 11) ? (CW + 2) : 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic [CW-1:0] wcnt,
  output logic [31:0]   rd_data,
  output logic          early_hit
);

  logic [5:0]      thr_q;
  logic [5:0]      thr_d;
  logic [CMPW-1:0] thr_bytes;
  logic [CMPW-1:0] byte_cnt;
  logic            thr_off;
  logic            unused_hi;

  assign unused_hi = ^wr_data[31:6];

  // next-state
  always_comb begin
    thr_d = thr_q;
    if (wr_en) begin
      thr_d = wr_data[5:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= THR_DISABLED;
    end else begin
      thr_q <= thr_d;
    end
  end

  // bytes required = 4 * (8*T + 1) = 32*T + 4
  always_comb begin
    thr_bytes = (CMPW'(thr_q) << 5) + CMPW'(4);
    byte_cnt  = CMPW'({wcnt, 2'b00});
    thr_off   = (thr_q == THR_DISABLED);
    early_hit = !thr_off && (byte_cnt >= thr_bytes);
    rd_data   = {26'd0, thr_q};
  end

  a_r1_thr_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(thr_q));

endmodule

// File: rtl/etx_word_buf.sv
module etx_word_buf #(
  parameter int WORDS = 512,
  parameter int CW    = $clog2(WORDS + 1),
  parameter int AW    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          flush,
  input  logic [CW-1:0] rd_widx,
  output logic [31:0]   rd_word,
  output logic [15:0]   hdr_len,
  output logic [CW-1:0] wcnt
);

  logic [31:0]   mem [WORDS];
  logic [CW-1:0] wcnt_q;
  logic [CW-1:0] wcnt_d;
  logic [AW-1:0] waddr;
  logic          full;
  logic          wr_ok;
  logic          unused_widx;

  assign unused_widx = ^(rd_widx >> AW);

  // next-state
  always_comb begin
    full   = (wcnt_q == CW'(WORDS));
    wr_ok  = wr_en && (flush || !full);
    waddr  = flush ? '0 : wcnt_q[AW-1:0];
    wcnt_d = wcnt_q;
    if (flush) begin
      wcnt_d = wr_en ? CW'(1) : '0;
    end else if (wr_ok) begin
      wcnt_d = wcnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else begin
      wcnt_q <= wcnt_d;
    end
  end

  // storage: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[waddr] <= wr_data;
    end
  end

  assign rd_word = mem[rd_widx[AW-1:0]];
  assign hdr_len = mem[0][15:0];
  assign wcnt    = wcnt_q;

  a_r8_capacity : assert property (@(posedge clk) disable iff (!rst_n)
    wcnt_q <= CW'(WORDS));

  a_r8_flush_empties : assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en) |=> (wcnt_q == '0));

endmodule

// File: rtl/etx_tx_seq.sv
module etx_tx_seq
  import etx_pkg::*;
#(
  parameter int CW = 10,
  parameter int BW = CW + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          early_hit,
  input  logic [CW-1:0] wcnt,
  input  logic [15:0]   hdr_len,
  input  logic [31:0]   rd_word,
  output logic [CW-1:0] rd_widx,
  output logic          flush,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_last,
  output logic          tx_err,
  output logic          tx_busy
);

  etx_state_e    state_q, state_d;
  logic [BW-1:0] idx_q, idx_d;
  logic [15:0]   rem_q, rem_d;
  logic          valid_q, valid_d;
  logic          last_q, last_d;
  logic          err_q, err_d;
  logic [7:0]    data_q, data_d;
  logic          trig;
  logic          avail;
  logic [7:0]    lane [4];
  logic [7:0]    sel_byte;

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign lane[b] = rd_word[8*b +: 8];
  end

  assign sel_byte = lane[idx_q[1:0]];

  // next-state
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    valid_d = 1'b0;
    last_d  = 1'b0;
    err_d   = 1'b0;
    data_d  = data_q;
    flush   = 1'b0;
    trig    = go || early_hit;
    rd_widx = idx_q[BW-1:2];
    avail   = (rd_widx < wcnt);
    case (state_q)
      ST_IDLE: begin
        if (trig) begin
          if (wcnt == '0) begin
            err_d = 1'b1;
            flush = 1'b1;
          end else if (hdr_len == 16'd0) begin
            flush = 1'b1;
          end else begin
            state_d = ST_SEND;
            idx_d   = BW'(HDR_BYTES);
            rem_d   = hdr_len;
          end
        end
      end
      ST_SEND: begin
        if (avail) begin
          valid_d = 1'b1;
          data_d  = sel_byte;
          last_d  = (rem_q == 16'd1);
          idx_d   = idx_q + BW'(1);
          rem_d   = rem_q - 16'd1;
          if (rem_q == 16'd1) begin
            state_d = ST_IDLE;
            flush   = 1'b1;
          end
        end else begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
          flush   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rem_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
      valid_q <= valid_d;
      last_q  <= last_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (valid_d) begin
      data_q <= data_d;
    end
  end

  assign tx_valid = valid_q;
  assign tx_data  = data_q;
  assign tx_last  = last_q;
  assign tx_err   = err_q;
  assign tx_busy  = (state_q == ST_SEND);

  a_r2_no_self_start : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !go && !early_hit) |=> (state_q == ST_IDLE));

  a_r7_err_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> (!tx_valid && !tx_last && !tx_busy));

  a_r5_last_closes : assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_valid && !tx_busy));

  a_r9_busy_ignores_go : assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && go && avail && rem_q != 16'd1) |=> tx_busy);

endmodule

// File: rtl/etx_start_ctrl.sv
module etx_start_ctrl #(
  parameter int FIFO_WORDS = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        thr_wr_en,
  input  logic [31:0] thr_wr_data,
  output logic [31:0] thr_rd_data,
  input  logic        fifo_wr_en,
  input  logic [31:0] fifo_wr_data,
  input  logic        tx_go,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_err,
  output logic        tx_busy
);

  localparam int CW = $clog2(FIFO_WORDS + 1);
  localparam int AW = (FIFO_WORDS > 1) ? $clog2(FIFO_WORDS) : 1;
  localparam int BW = CW + 2;

  logic          rst_n_s;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] rd_widx;
  logic [31:0]   rd_word;
  logic [15:0]   hdr_len;
  logic          early_hit;
  logic          flush;

  etx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  etx_thr_reg #(.CW(CW)) u_thr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (thr_wr_en),
    .wr_data   (thr_wr_data),
    .wcnt      (wcnt),
    .rd_data   (thr_rd_data),
    .early_hit (early_hit)
  );

  etx_word_buf #(.WORDS(FIFO_WORDS), .CW(CW), .AW(AW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (fifo_wr_en),
    .wr_data (fifo_wr_data),
    .flush   (flush),
    .rd_widx (rd_widx),
    .rd_word (rd_word),
    .hdr_len (hdr_len),
    .wcnt    (wcnt)
  );

  etx_tx_seq #(.CW(CW), .BW(BW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .go        (tx_go),
    .early_hit (early_hit),
    .wcnt      (wcnt),
    .hdr_len   (hdr_len),
    .rd_word   (rd_word),
    .rd_widx   (rd_widx),
    .flush     (flush),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_err    (tx_err),
    .tx_busy   (tx_busy)
  );

  a_r3_hit_starts : assert property (@(posedge clk) disable iff (!rst_n_s)
    (!tx_busy && early_hit && hdr_len != 16'd0) |=> tx_busy);

endmodule

// File: tb/etx_start_ctrl_tb_top.sv
`timescale 1ns/100ps
module etx_start_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        thr_wr_en;
  logic [31:0] thr_wr_data;
  logic [31:0] thr_rd_data;
  logic        fifo_wr_en;
  logic [31:0] fifo_wr_data;
  logic        tx_go;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        tx_err;
  logic        tx_busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0] mon_b   [0:4095];
  int         mon_cyc [0:4095];
  int nb = 0, n_last = 0, last_pos = 0, n_err = 0, busy_cyc = 0;

  etx_start_ctrl #(.FIFO_WORDS(512)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_wr_en    (thr_wr_en),
    .thr_wr_data  (thr_wr_data),
    .thr_rd_data  (thr_rd_data),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data),
    .tx_go        (tx_go),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .tx_err       (tx_err),
    .tx_busy      (tx_busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tx_valid && nb < 4096) begin
      mon_b[nb]   = tx_data;
      mon_cyc[nb] = cyc;
      nb = nb + 1;
      if (tx_last) begin
        n_last   = n_last + 1;
        last_pos = nb;
      end
    end
    if (tx_err)  n_err    = n_err + 1;
    if (tx_busy) busy_cyc = busy_cyc + 1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int salt);
    return 8'((k * 13 + salt) & 255);
  endfunction

  function automatic logic [31:0] mk_word(input int w, input int len, input int salt);
    logic [31:0] r;
    for (int p = 0; p < 4; p++) begin
      int k;
      k = 4 * w + p;
      if (k == 0)      r[8*p +: 8] = 8'(len & 255);
      else if (k == 1) r[8*p +: 8] = 8'((len >> 8) & 255);
      else             r[8*p +: 8] = pat(k, salt);
    end
    return r;
  endfunction

  task automatic mon_clear();
    #1;
    nb = 0; n_last = 0; last_pos = 0; n_err = 0; busy_cyc = 0;
  endtask

  task automatic wr_thr(input logic [31:0] v);
    thr_wr_en   = 1'b1;
    thr_wr_data = v;
    @(negedge clk);
    thr_wr_en   = 1'b0;
  endtask

  task automatic push(input logic [31:0] d);
    fifo_wr_en   = 1'b1;
    fifo_wr_data = d;
    @(negedge clk);
    fifo_wr_en   = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_go();
    tx_go = 1'b1;
    @(negedge clk);
    tx_go = 1'b0;
  endtask

  task automatic wait_idle(input int maxc);
    int c;
    c = 0;
    while (tx_busy && c < maxc) begin
      @(negedge clk);
      c++;
    end
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic check_frame(input int len, input int salt, input string req);
    int bad;
    int gaps;
    int first_bad;
    bad = 0; gaps = 0; first_bad = -1;
    check(nb == len, {req, " R5 byte count"}, nb, len);
    for (int i = 0; i < nb && i < len; i++) begin
      if (mon_b[i] !== pat(i + 2, salt)) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
      if (i > 0 && mon_cyc[i] != mon_cyc[i-1] + 1) gaps++;
    end
    check(bad == 0, {req, " R5 payload bytes"},
          (first_bad < 0) ? 0 : mon_b[first_bad],
          (first_bad < 0) ? 0 : pat(first_bad + 2, salt));
    check(gaps == 0, {req, " R10 one byte per clock"}, gaps, 0);
    check(n_last == 1 && last_pos == len, {req, " R5 last marker"}, last_pos, len);
    check(n_err == 0, {req, " R7 no error"}, n_err, 0);
  endtask

  task automatic push_frame(input int len, input int salt, input string req, input bit chk_idle);
    int nw;
    nw = (len + 2 + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      push(mk_word(w, len, salt));
      if (chk_idle) check(tx_busy == 1'b0, req, tx_busy, 0);
    end
  endtask

  task automatic run_thr(input int t, input int salt);
    int thr;
    int len;
    int nw;
    int n;
    thr = 4 * (8 * t + 1);
    len = thr + 10;
    nw  = (len + 2 + 3) / 4;
    n   = thr / 4;
    wr_thr(32'(t));
    mon_clear();
    for (int w = 0; w < nw; w++) begin
      push(mk_word(w, len, salt));
      if (w + 1 <= n) begin
        check(tx_busy == ((w + 1) >= n), "R3 early start point",
              tx_busy, ((w + 1) >= n));
      end
    end
    wait_idle(4000);
    check_frame(len, salt, "R3 R9 threshold frame");
  endtask

  initial begin
    rst_n = 1'b0; thr_wr_en = 1'b0; thr_wr_data = '0;
    fifo_wr_en = 1'b0; fifo_wr_data = '0; tx_go = 1'b0;
    repeat (4) @(negedge clk);
    check(thr_rd_data == 32'h3F, "R1 reset value", thr_rd_data, 32'h3F);
    check(tx_busy == 1'b0 && tx_valid == 1'b0, "R1 reset idle", tx_busy, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 register access
    wr_thr(32'hFFFF_FFC5);
    check(thr_rd_data == 32'h05, "R1 write low field", thr_rd_data, 32'h05);
    wr_thr(32'h0000_003F);
    check(thr_rd_data == 32'h3F, "R1 disable value", thr_rd_data, 32'h3F);

    // R2: disabled threshold, go required
    mon_clear();
    push_frame(30, 1, "R2 no early start when disabled", 1'b1);
    repeat (10) @(negedge clk);
    #1;
    check(busy_cyc == 0, "R2 stays idle", busy_cyc, 0);
    pulse_go();
    wait_idle(500);
    check_frame(30, 1, "R2 go frame");

    // R4: short frame below threshold
    wr_thr(32'd5);
    mon_clear();
    push_frame(9, 2, "R4 below threshold idle", 1'b1);
    pulse_go();
    wait_idle(500);
    check_frame(9, 2, "R4 forced short frame");

    // R9: retriggers while busy are ignored
    wr_thr(32'h3F);
    mon_clear();
    push_frame(40, 3, "R9 prefill idle", 1'b1);
    pulse_go();
    repeat (4) @(negedge clk);
    pulse_go();
    wr_thr(32'd0);
    wait_idle(500);
    repeat (10) @(negedge clk);
    #1;
    check_frame(40, 3, "R9 single frame");
    check(tx_busy == 1'b0, "R9 idle after frame", tx_busy, 0);
    check(busy_cyc == 40, "R9 busy length", busy_cyc, 40);

    // R6: zero-length frame
    wr_thr(32'h3F);
    mon_clear();
    push(mk_word(0, 0, 7));
    pulse_go();
    wait_idle(100);
    check(nb == 0, "R6 no bytes", nb, 0);
    check(n_err == 0, "R6 no error", n_err, 0);
    check(busy_cyc == 0, "R6 never busy", busy_cyc, 0);

    // R7: underrun after header word
    wr_thr(32'd0);
    mon_clear();
    push(mk_word(0, 20, 4));
    wait_idle(100);
    check(nb == 2, "R7 bytes before underrun", nb, 2);
    check(nb >= 2 && mon_b[0] == pat(2, 4) && mon_b[1] == pat(3, 4),
          "R7 bytes before underrun value", mon_b[0], pat(2, 4));
    check(n_err == 1, "R7 error pulse", n_err, 1);
    check(n_last == 0, "R7 no last on abort", n_last, 0);

    // R7/R8: empty start after abort-flush
    mon_clear();
    pulse_go();
    wait_idle(100);
    check(n_err == 1 && nb == 0, "R7 empty start error", n_err, 1);
    check(busy_cyc == 0, "R8 buffer empty after abort", busy_cyc, 0);

    // R8: fresh frame after abort
    wr_thr(32'h3F);
    mon_clear();
    push_frame(7, 5, "R8 idle while filling", 1'b1);
    pulse_go();
    wait_idle(200);
    check_frame(7, 5, "R8 frame after flush");

    // R3 sweep, also R9 re-arm between frames
    for (int t = 0; t <= 5; t++) run_thr(t, t + 10);
    run_thr(10, 20);

    // R8: full buffer drops the extra word
    wr_thr(32'h3F);
    mon_clear();
    push_frame(2046, 6, "R8 fill idle", 1'b0);
    push(32'h0000_0000);
    check(tx_busy == 1'b0, "R8 idle at capacity", tx_busy, 0);
    pulse_go();
    wait_idle(3000);
    check_frame(2046, 6, "R8 overflow word dropped");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule